// File: doc/BRIEF.md
# Erase-Block Write Protection Manager

This block holds a lock state for every erase block of a flash array and changes those states on command. Three one-hot states exist: open (writable), locked, and sealed. A sealed block can only leave that state through reset. Software first loads a first-block and last-block index. It then issues one of four command codes: open a range, close a range, seal a range, or open every block. The manager then visits the chosen blocks one per clock, starting at the lowest index.

Open and close walks halt as soon as they meet a sealed block. That block and every block after it keep their state. A seal walk steps over open blocks and carries on to the end of the range. A walk that reaches an index past the last real block stops and flags an error. Each block that is changed also copies its new state into a status register. When a walk ends, the block pulses done (and error, if one occurred) toward the interrupt controller.

A combinational lookup port lets program and erase logic ask for the state of any block at any time.

Top module: `blk_protect_mgr`

## Requirements
- R1: After synchronous reset every block reads locked (3'b010), the status register reads 3'b010, busy and done are low, and both range registers read 0.
- R2: A range write with cfg_sel=0 loads both the first and last index with the low IDX_W bits of cfg_data. A range write with cfg_sel=1 loads only the last index with those bits. IDX_W is clog2(NUM_BLOCKS), so the mask is NUM_BLOCKS-1 for a power-of-two count.
- R3: Command 8'h23 sets every block from the first to the last index, inclusive, to open (3'b100). Blocks outside that range keep their state.
- R4: Command 8'h2A sets every block from the first to the last index, inclusive, to locked (3'b010).
- R5: Command 8'h27 opens every block, walking upward from index 0 to NUM_BLOCKS-1, and ignores the range registers.
- R6: During an open or close walk (8'h23, 8'h27, 8'h2A), meeting a sealed block (3'b001) ends the walk at that block. That block and all later blocks are left unchanged.
- R7: Command 8'h2C seals (3'b001) every block in the range that is not open. Open blocks are skipped and the walk continues past them.
- R8: If the walk reaches an index at or above NUM_BLOCKS, it stops there and cmd_err is high in the same cycle as done. Blocks modified before that point keep their new state.
- R9: Each modified block copies its new state into wp_status, so wp_status holds the state of the last modified block. A walk that modifies nothing leaves wp_status unchanged, including a walk where the first index exceeds the last.
- R10: Busy rises the cycle after a command is accepted. It stays high for one cycle per index examined, including the index that ends the walk, and for exactly one cycle when the first index exceeds the last. Done is high for exactly one cycle, in the first cycle busy is low.
- R11: While busy, command requests and range writes are ignored. A command code outside the four listed is ignored at any time: busy and done stay low and no state changes.
- R12: lk_state returns the current state of block lk_idx in the same cycle. It returns 3'b000 for an index at or above NUM_BLOCKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Range register write strobe |
| cfg_sel | input | 1 | 0: first index (also loads last), 1: last index only |
| cfg_data | input | DATA_W | Range write data |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 8 | Command code |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| cmd_err | output | 1 | Out-of-range error, valid with done |
| wp_status | output | 3 | Last written block state |
| range_start | output | IDX_W | First index register |
| range_end | output | IDX_W | Last index register |
| lk_idx | input | IDX_W | Lookup block index |
| lk_state | output | 3 | Lookup result |

## Verification
On every cycle, the assertions check the following:
- every block state stays one-hot, and a sealed block stays sealed;
- done lasts one cycle and coincides with busy falling;
- errors appear only with done;
- no write lands beyond the array;
- the range registers hold still during a walk.

Only the bench scenarios can show that a walk modifies the right set of blocks. The same applies to stopping at a sealed block against skipping open ones, to the exact number of busy cycles, and to which value ends up in the status register. For these, the bench compares the full block map after every command with its own model.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [2:0] {
        LK_TIGHT  = 3'b001,
        LK_LOCKED = 3'b010,
        LK_OPEN   = 3'b100
    } lock_e;

    typedef enum logic [1:0] {
        OP_OPEN  = 2'd0,
        OP_CLOSE = 2'd1,
        OP_SEAL  = 2'd2
    } op_e;

    localparam logic [7:0] CMD_OPEN_RANGE  = 8'h23;
    localparam logic [7:0] CMD_OPEN_ALL    = 8'h27;
    localparam logic [7:0] CMD_CLOSE_RANGE = 8'h2A;
    localparam logic [7:0] CMD_SEAL_RANGE  = 8'h2C;

    typedef struct packed {
        logic hit;
        logic whole;
        op_e  op;
    } cmd_dec_t;

    typedef struct packed {
        logic       fin;
        logic       wr;
        logic       err;
        logic [2:0] val;
    } step_t;

    function automatic cmd_dec_t decode_cmd(input logic [7:0] code);
        cmd_dec_t d;
        d = '{hit: 1'b0, whole: 1'b0, op: OP_OPEN};
        case (code)
            CMD_OPEN_RANGE:  d = '{hit: 1'b1, whole: 1'b0, op: OP_OPEN};
            CMD_OPEN_ALL:    d = '{hit: 1'b1, whole: 1'b1, op: OP_OPEN};
            CMD_CLOSE_RANGE: d = '{hit: 1'b1, whole: 1'b0, op: OP_CLOSE};
            CMD_SEAL_RANGE:  d = '{hit: 1'b1, whole: 1'b0, op: OP_SEAL};
            default:         d.hit = 1'b0;
        endcase
        return d;
    endfunction

    // One walk step: decides write, error and termination for the visited block.
    function automatic step_t walk_step(input op_e op, input logic [2:0] cur,
                                        input logic past_end, input logic oob,
                                        input logic at_last);
        step_t s;
        s = '{fin: 1'b0, wr: 1'b0, err: 1'b0, val: 3'b000};
        if (past_end) begin
            s.fin = 1'b1;
        end else if (oob) begin
            s.fin = 1'b1;
            s.err = 1'b1;
        end else if (op == OP_SEAL) begin
            if (cur != LK_OPEN) begin
                s.wr  = 1'b1;
                s.val = LK_TIGHT;
            end
            s.fin = at_last;
        end else if (cur == LK_TIGHT) begin
            s.fin = 1'b1;
        end else begin
            s.wr  = 1'b1;
            s.val = (op == OP_OPEN) ? LK_OPEN : LK_LOCKED;
            s.fin = at_last;
        end
        return s;
    endfunction

endpackage

// File: rtl/wp_range_regs.sv
module wp_range_regs #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hold,
    output logic [IDX_W-1:0]  start_q,
    output logic [IDX_W-1:0]  end_q
);
    logic [IDX_W-1:0] masked;
    assign masked = wr_data[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            end_q   <= '0;
        end else if (wr_en && !hold) begin
            if (!wr_sel) begin
                start_q <= masked;
                end_q   <= masked;
            end else begin
                end_q <= masked;
            end
        end
    end

    AST_RANGE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(start_q) && $stable(end_q))); // R11

endmodule

// File: rtl/wp_state_array.sv
module wp_state_array
    import wp_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [2:0]       wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [2:0]       rd_val,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [2:0]       lk_val
);
    logic [NUM_BLOCKS-1:0][2:0] st_all;

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
        logic [2:0] st_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= LK_LOCKED;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                st_q <= wr_val;
            end
        end
        assign st_all[g] = st_q;

        AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
            $countones(st_q) == 1); // R1
        AST_SEAL_STICKY: assert property (@(posedge clk) disable iff (rst)
            (st_q == LK_TIGHT) |=> (st_q == LK_TIGHT)); // R6
    end

    always_comb begin
        rd_val = 3'b000;
        lk_val = 3'b000;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_val = st_all[i];
            if (lk_idx == IDX_W'(i)) lk_val = st_all[i];
        end
    end

endmodule

// File: rtl/wp_walker.sv
module wp_walker
    import wp_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    input  logic [IDX_W-1:0] start_q,
    input  logic [IDX_W-1:0] end_q,
    input  logic [2:0]       rd_val,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [2:0]       wr_val,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [2:0]       wp_status
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);

    logic             busy_q, done_q, err_q;
    logic [IDX_W-1:0] cur_q, last_q;
    op_e              op_q;
    logic [2:0]       status_q;
    cmd_dec_t         dec;
    step_t            step;

    assign dec  = decode_cmd(cmd_code);
    assign step = walk_step(op_q, rd_val, cur_q > last_q,
                            int'(cur_q) >= NUM_BLOCKS, cur_q == last_q);

    assign rd_idx = cur_q;
    assign wr_idx = cur_q;
    assign wr_en  = busy_q && step.wr;
    assign wr_val = step.val;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            cur_q    <= '0;
            last_q   <= '0;
            op_q     <= OP_OPEN;
            status_q <= LK_LOCKED;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (!busy_q) begin
                if (cmd_valid && dec.hit) begin
                    busy_q <= 1'b1;
                    op_q   <= dec.op;
                    cur_q  <= dec.whole ? '0 : start_q;
                    last_q <= dec.whole ? LAST_IDX : end_q;
                end
            end else begin
                if (step.wr) status_q <= step.val;
                if (step.fin) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    err_q  <= step.err;
                end else begin
                    cur_q <= cur_q + 1'b1;
                end
            end
        end
    end

    assign busy      = busy_q;
    assign done      = done_q;
    assign err       = err_q;
    assign wp_status = status_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R10
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> done); // R8
    AST_WRITE_INSIDE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < NUM_BLOCKS)); // R8
    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(wp_status) == 1); // R9

endmodule

// File: rtl/blk_protect_mgr.sv
module blk_protect_mgr
    import wp_pkg::*;
#(
    parameter int NUM_BLOCKS = 12,
    parameter int DATA_W     = 16,
    localparam int IDX_W     = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    output logic              busy,
    output logic              done,
    output logic              cmd_err,
    output logic [2:0]        wp_status,
    output logic [IDX_W-1:0]  range_start,
    output logic [IDX_W-1:0]  range_end,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [2:0]        lk_state
);
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [2:0]       wr_val, rd_val;

    wp_range_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_range (
        .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_sel(cfg_sel),
        .wr_data(cfg_data), .hold(busy),
        .start_q(range_start), .end_q(range_end)
    );

    wp_state_array #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .rd_idx(rd_idx), .rd_val(rd_val), .lk_idx(lk_idx), .lk_val(lk_state)
    );

    wp_walker #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_walk (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .start_q(range_start), .end_q(range_end), .rd_val(rd_val),
        .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
        .busy(busy), .done(done), .err(cmd_err), .wp_status(wp_status)
    );

endmodule

// File: tb/blk_protect_mgr_test.sv
`timescale 1ns/1ps
module blk_protect_mgr_test;
    localparam int NB = 12;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [15:0]   cfg_data = '0;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = '0;
    logic          busy, done, cmd_err;
    logic [2:0]    wp_status, lk_state;
    logic [IW-1:0] range_start, range_end;
    logic [IW-1:0] lk_idx = '0;

    always #2.5 clk = ~clk;

    blk_protect_mgr #(.NUM_BLOCKS(NB), .DATA_W(16)) uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .busy(busy), .done(done), .cmd_err(cmd_err), .wp_status(wp_status),
        .range_start(range_start), .range_end(range_end),
        .lk_idx(lk_idx), .lk_state(lk_state)
    );

    int nchk = 0, nfail = 0;
    bit finished = 0;
    logic [2:0] exp_st [NB];
    logic [2:0] exp_status;
    int exp_start, exp_end;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int b = 0; b < 16; b++) begin
            lk_idx = IW'(b);
            #0.5;
            chk({req, (b >= NB) ? " R12 lookup beyond count" : " block map"},
                int'(lk_state), (b < NB) ? int'(exp_st[b]) : 0);
        end
        chk({req, " R9 status"}, int'(wp_status), int'(exp_status));
        chk({req, " R2 range start"}, int'(range_start), exp_start);
        chk({req, " R2 range end"}, int'(range_end), exp_end);
    endtask

    function automatic bit known(input logic [7:0] c);
        return c == 8'h23 || c == 8'h27 || c == 8'h2A || c == 8'h2C;
    endfunction

    // Reference walk from the requirements; returns examined count and error.
    task automatic model_cmd(input logic [7:0] c, output int steps, output bit err);
        int s, l, b;
        logic [2:0] nv;
        s = (c == 8'h27) ? 0 : exp_start;
        l = (c == 8'h27) ? NB - 1 : exp_end;
        nv = (c == 8'h2A) ? 3'b010 : 3'b100;
        steps = 0; err = 0; b = s;
        forever begin
            steps++;
            if (b > l) break;
            if (b >= NB) begin err = 1; break; end
            if (c == 8'h2C) begin
                if (exp_st[b] != 3'b100) begin exp_st[b] = 3'b001; exp_status = 3'b001; end
            end else begin
                if (exp_st[b] == 3'b001) break;
                exp_st[b] = nv; exp_status = nv;
            end
            if (b == l) break;
            b++;
        end
    endtask

    task automatic cfg_write(input bit sel, input logic [15:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (!sel) exp_start = int'(v[IW-1:0]);
        exp_end = int'(v[IW-1:0]);
    endtask

    // Optional interference while busy checks R11.
    task automatic run_cmd(input logic [7:0] c, input string req, input bit poke);
        int steps, bc;
        bit err;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!known(c)) begin
            chk({req, " R11 unknown code busy"}, int'(busy), 0);
            @(negedge clk);
            chk({req, " R11 unknown code done"}, int'(done), 0);
            check_all(req);
            return;
        end
        model_cmd(c, steps, err);
        bc = 0;
        if (poke && busy) begin
            cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_data = 16'h0009;
            cmd_valid = 1'b1; cmd_code = 8'h2A;
            bc++;
            @(negedge clk);
            cfg_wr = 1'b0; cmd_valid = 1'b0;
        end
        while (busy && bc < 100) begin
            bc++;
            @(negedge clk);
        end
        chk({req, " R10 busy cycles"}, bc, steps);
        chk({req, " R10 done pulse"}, int'(done), 1);
        chk({req, " R8 error flag"}, int'(cmd_err), int'(err));
        @(negedge clk);
        chk({req, " R10 done single"}, int'(done), 0);
        check_all(req);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL R10 watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd20611);
        for (int b = 0; b < NB; b++) exp_st[b] = 3'b010;
        exp_status = 3'b010; exp_start = 0; exp_end = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy at reset", int'(busy), 0);
        chk("R1 done at reset", int'(done), 0);
        check_all("R1 reset");

        cfg_write(1'b0, 16'h0013);            // R2 both loaded with 3
        cfg_write(1'b1, 16'h0025);            // R2 end only, 5
        check_all("R2 range writes");

        run_cmd(8'h5A, "R11 unknown", 1'b0);
        run_cmd(8'h27, "R5 open all with R11 poke", 1'b1);

        cfg_write(1'b0, 16'h0000);
        cfg_write(1'b1, 16'h0005);
        run_cmd(8'h2A, "R4 close 0..5", 1'b0);
        cfg_write(1'b0, 16'h0003);
        cfg_write(1'b1, 16'h0005);
        run_cmd(8'h23, "R3 open 3..5", 1'b0);
        cfg_write(1'b0, 16'h0007);
        cfg_write(1'b1, 16'h0002);
        run_cmd(8'h23, "R9 empty walk", 1'b0);
        cfg_write(1'b0, 16'h0002);
        cfg_write(1'b1, 16'h0006);
        run_cmd(8'h2C, "R7 seal skips open", 1'b0);
        run_cmd(8'h27, "R6 open all halts", 1'b0);
        cfg_write(1'b0, 16'h0000);
        cfg_write(1'b1, 16'h0008);
        run_cmd(8'h2A, "R6 close halts", 1'b0);
        cfg_write(1'b0, 16'h000A);
        cfg_write(1'b1, 16'h000E);
        run_cmd(8'h23, "R8 beyond count", 1'b0);
        cfg_write(1'b0, 16'h000D);
        run_cmd(8'h2C, "R8 start beyond", 1'b0);

        for (int i = 0; i < 60; i++) begin
            logic [7:0] c;
            int pick;
            if ($urandom_range(0, 1) == 1) cfg_write(1'b0, 16'($urandom()));
            if ($urandom_range(0, 1) == 1) cfg_write(1'b1, 16'($urandom()));
            pick = $urandom_range(0, 9);
            case (pick)
                0, 1, 2: c = 8'h23;
                3, 4:    c = 8'h2A;
                5:       c = 8'h27;
                6, 7:    c = 8'h2C;
                default: c = 8'($urandom());
            endcase
            run_cmd(c, "R3 random mix", pick == 5);
        end

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule